// File: doc/BRIEF.md
# 64-bit Free-Running Timer with Compare Event

This block is a memory-mapped timer. It holds a 64-bit up-counter that advances by one on every clock while its run bit is set. There is no prescaler. A 64-bit compare value sits beside the counter. When the compare unit is armed and enabled, and the count is at or beyond the compare value, a sticky event flag sets. That flag, gated by an interrupt-enable bit, drives a level interrupt line. In periodic mode each event adds a 32-bit step to the compare value, so events repeat at a fixed spacing without software help.

Software reaches the timer over a plain 32-bit register bus with separate read and write strobes, a byte address and write and read data. Every 64-bit quantity appears as a low and a high half. A consistent counter value is obtained by reading high, low, high and retrying until both high reads agree. To move the compare point, software clears the compare enable, writes both halves, then sets compare enable and interrupt enable again. Control and status pins are plain single-cycle strobes. There is no valid/ready stream at this edge, so the bus has no back-pressure: every access completes in the cycle its strobe is high.

Byte offsets:

| Offset | Register |
|---|---|
| 0x00 | counter low half |
| 0x04 | counter high half |
| 0x08 | control |
| 0x0C | status |
| 0x10 | compare low half |
| 0x14 | compare high half |
| 0x18 | periodic step |

Control bits: bit 0 run, bit 1 compare enable, bit 2 interrupt enable, bit 3 periodic mode. Status bit 0 is the event flag.

Top module: `gt_timer64`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: While control bit 0 is 1, the counter rises by exactly one per clock. While it is 0, the counter holds its value.
- R3: A write to the counter low half (0x00) or high half (0x04) loads that half at the next edge. The write takes precedence over that cycle's increment.
- R4: Reads are combinational in the strobe cycle. Reading 0x00 returns the live count of that cycle.
- R5: With control bit 1 set and the compare unit armed, the status flag (bit 0 of 0x0C) sets one cycle after the count is greater than or equal to the compare value, not only on equality.
- R6: While control bit 1 is clear, the flag never sets, whatever the count or compare values are.
- R7: Outside periodic mode, an event disarms the compare unit, so after the flag is cleared it does not set again. The unit re-arms only on a write to either compare half or on a control write that takes bit 1 from 0 to 1.
- R8: In periodic mode (control bit 3), each event adds the step register (0x18) to the compare value, and the unit stays armed.
- R9: Writing 1 to status bit 0 clears the flag. Writing 0 leaves it unchanged. A new event in the same cycle wins over the clear.
- R10: `irq` is high exactly when the flag is set and control bit 2 is set. It stays high until the flag is cleared or bit 2 is cleared.
- R11: The counter wraps from all ones to zero and keeps counting. The wrap raises no event by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle, zero otherwise |
| irq | output | 1 | Level interrupt: flag AND interrupt enable |

## Verification
The assertions run on every cycle and cover the following:
- the counter steps by one or holds, and a half written over the bus loads as written;
- no flag can appear while compare is disabled or the unit is disarmed;
- an at-or-beyond match always sets the flag on the next edge;
- periodic mode moves the compare value by exactly one step per event;
- a write-one clear takes effect;
- the interrupt line does not drop without a clear or a control write.

Only the bench's scenarios can show the rest. These are the live count seen through the low-half read, the wrap across 64 bits, that a compare value already below the count fires at once, that a cleared one-shot event stays quiet until re-enable, and the final compare value after a chain of periodic catch-up events.

// File: rtl/gt_pkg.sv
`timescale 1ns/1ps
package gt_pkg;
  localparam int OFF_CNT_LO = 'h00;
  localparam int OFF_CNT_HI = 'h04;
  localparam int OFF_CTRL   = 'h08;
  localparam int OFF_STAT   = 'h0C;
  localparam int OFF_CMP_LO = 'h10;
  localparam int OFF_CMP_HI = 'h14;
  localparam int OFF_STEP   = 'h18;

  localparam int CTRL_W = 4;

  typedef struct packed {
    logic periodic;  // bit 3
    logic irq_en;    // bit 2
    logic cmp_en;    // bit 1
    logic run;       // bit 0
  } ctrl_t;
endpackage

// File: rtl/gt_counter.sv
`timescale 1ns/1ps
module gt_counter #(
  parameter int HALF_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [1:0]          ld,
  input  logic [HALF_W-1:0]   ld_data,
  output logic [2*HALF_W-1:0] cnt
);
  localparam int CNT_W = 2 * HALF_W;
  localparam int NHALF = 2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (|ld) begin
      for (int h = 0; h < NHALF; h++)
        if (ld[h]) cnt[h*HALF_W +: HALF_W] <= ld_data;
    end else if (run) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !(|ld)) |=> (cnt == $past(cnt) + CNT_W'(1)));
  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(|ld)) |=> $stable(cnt));
  p_load_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld[0] |=> (cnt[HALF_W-1:0] == $past(ld_data)));
  p_load_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld[1] |=> (cnt[CNT_W-1:HALF_W] == $past(ld_data)));
endmodule

// File: rtl/gt_compare.sv
`timescale 1ns/1ps
module gt_compare #(
  parameter int HALF_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*HALF_W-1:0] cnt,
  input  logic                cmp_en,
  input  logic                periodic,
  input  logic [1:0]          cmp_ld,
  input  logic                step_ld,
  input  logic                rearm,
  input  logic                clr,
  input  logic [HALF_W-1:0]   wdata,
  output logic [2*HALF_W-1:0] cmp,
  output logic [HALF_W-1:0]   step,
  output logic                flag
);
  localparam int CNT_W = 2 * HALF_W;
  localparam int NHALF = 2;

  logic armed;
  logic hit;

  assign hit = cmp_en && armed && (cnt >= cmp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp <= '0;
    end else if (|cmp_ld) begin
      for (int h = 0; h < NHALF; h++)
        if (cmp_ld[h]) cmp[h*HALF_W +: HALF_W] <= wdata;
    end else if (hit && periodic) begin
      cmp <= cmp + CNT_W'(step);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       step <= '0;
    else if (step_ld) step <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      armed <= 1'b0;
    else if ((|cmp_ld) || rearm)     armed <= 1'b1;
    else if (hit && !periodic)       armed <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  p_ge_fires_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && armed && (cnt >= cmp)) |=> flag);
  p_off_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_en && !flag) |=> !flag);
  p_disarmed_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !flag) |=> !flag);
  p_step_add_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && armed && periodic && (cnt >= cmp) && !(|cmp_ld))
      |=> (cmp == $past(cmp) + CNT_W'($past(step))));
  p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(cmp_en && armed && (cnt >= cmp))) |=> !flag);
endmodule

// File: rtl/gt_timer64.sv
`timescale 1ns/1ps
module gt_timer64 #(
  parameter int HALF_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [HALF_W-1:0] bus_wdata,
  output logic [HALF_W-1:0] bus_rdata,
  output logic              irq
);
  import gt_pkg::*;
  localparam int CNT_W = 2 * HALF_W;

  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cmp;
  logic [HALF_W-1:0] step;
  logic              flag;

  logic sel_cnt_lo, sel_cnt_hi, sel_ctrl, sel_stat, sel_cmp_lo, sel_cmp_hi, sel_step;
  assign sel_cnt_lo = (bus_addr == ADDR_W'(OFF_CNT_LO));
  assign sel_cnt_hi = (bus_addr == ADDR_W'(OFF_CNT_HI));
  assign sel_ctrl   = (bus_addr == ADDR_W'(OFF_CTRL));
  assign sel_stat   = (bus_addr == ADDR_W'(OFF_STAT));
  assign sel_cmp_lo = (bus_addr == ADDR_W'(OFF_CMP_LO));
  assign sel_cmp_hi = (bus_addr == ADDR_W'(OFF_CMP_HI));
  assign sel_step   = (bus_addr == ADDR_W'(OFF_STEP));

  logic       ctrl_wr, clr_wr, rearm, step_wr;
  logic [1:0] cnt_ld, cmp_ld;
  ctrl_t      ctrl_new;

  assign ctrl_new = ctrl_t'(bus_wdata[CTRL_W-1:0]);
  assign ctrl_wr  = bus_wr && sel_ctrl;
  assign clr_wr   = bus_wr && sel_stat && bus_wdata[0];
  assign rearm    = ctrl_wr && ctrl_new.cmp_en && !ctrl_q.cmp_en;
  assign step_wr  = bus_wr && sel_step;
  assign cnt_ld   = {bus_wr && sel_cnt_hi, bus_wr && sel_cnt_lo};
  assign cmp_ld   = {bus_wr && sel_cmp_hi, bus_wr && sel_cmp_lo};

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_new;
  end

  gt_counter #(.HALF_W(HALF_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q.run),
    .ld      (cnt_ld),
    .ld_data (bus_wdata),
    .cnt     (cnt)
  );

  gt_compare #(.HALF_W(HALF_W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt      (cnt),
    .cmp_en   (ctrl_q.cmp_en),
    .periodic (ctrl_q.periodic),
    .cmp_ld   (cmp_ld),
    .step_ld  (step_wr),
    .rearm    (rearm),
    .clr      (clr_wr),
    .wdata    (bus_wdata),
    .cmp      (cmp),
    .step     (step),
    .flag     (flag)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (sel_cnt_lo) bus_rdata = cnt[HALF_W-1:0];
      if (sel_cnt_hi) bus_rdata = cnt[CNT_W-1:HALF_W];
      if (sel_ctrl)   bus_rdata = {{(HALF_W-CTRL_W){1'b0}}, ctrl_q};
      if (sel_stat)   bus_rdata = {{(HALF_W-1){1'b0}}, flag};
      if (sel_cmp_lo) bus_rdata = cmp[HALF_W-1:0];
      if (sel_cmp_hi) bus_rdata = cmp[CNT_W-1:HALF_W];
      if (sel_step)   bus_rdata = step;
    end
  end

  assign irq = flag && ctrl_q.irq_en;

  p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_wr && !ctrl_wr) |=> irq);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!irq && (cnt == '0)));
endmodule

// File: tb/sim_gt_timer64.sv
`timescale 1ns/1ps
module sim_gt_timer64;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int vectors = 0;
  int miscmp  = 0;
  bit done    = 1'b0;

  localparam logic [4:0] A_CLO = 5'h00, A_CHI = 5'h04, A_CTL = 5'h08,
                         A_STA = 5'h0C, A_MLO = 5'h10, A_MHI = 5'h14, A_STP = 5'h18;

  gt_timer64 u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      miscmp++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1; rd = 1'b0;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
    addr = a; rd = 1'b1;
    #1;
    d = rdata;
    rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected compare value after a chain of periodic catch-up events
  function automatic logic [31:0] exp_periodic(input logic [31:0] c0, input logic [31:0] st,
                                               input logic [31:0] cnt);
    logic [31:0] c = c0;
    while (c <= cnt) c = c + st;
    return c;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscmp++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, a, b;
    void'($urandom(32'd1234));
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    foreach (A_LIST[i]) begin
      rd_reg(A_LIST[i], v);
      check("R1 reset register", v, 0);
    end
    check("R1 reset irq", irq, 0);

    // R3 loads while stopped, R2 hold
    wr_reg(A_CLO, 32'd100);
    rd_reg(A_CLO, v); check("R3 low half load", v, 100);
    wr_reg(A_CHI, 32'd5);
    rd_reg(A_CHI, v); check("R3 high half load", v, 5);
    idle(4);
    rd_reg(A_CLO, v); check("R2 hold when stopped", v, 100);
    wr_reg(A_CHI, 32'd0);

    // R2/R4 running: live count difference over random gaps
    wr_reg(A_CTL, 32'h1);
    for (int i = 0; i < 5; i++) begin
      int k = $urandom_range(1, 40);
      rd_reg(A_CLO, a);
      idle(k);
      rd_reg(A_CLO, b);
      check("R2 R4 step per cycle", b - a, k);
    end

    // R3 write wins over increment
    wr_reg(A_CLO, 32'h1000);
    rd_reg(A_CLO, v); check("R3 write precedence", v, 32'h1000);
    idle(1);
    rd_reg(A_CLO, v); check("R4 live count", v, 32'h1001);

    // R11 wrap
    wr_reg(A_CTL, 32'h0);
    wr_reg(A_CLO, 32'hFFFF_FFFD);
    wr_reg(A_CHI, 32'hFFFF_FFFF);
    wr_reg(A_CTL, 32'h1);
    idle(5);
    rd_reg(A_CHI, v); check("R11 wrap high", v, 0);
    rd_reg(A_CLO, v); check("R11 wrap low", v, 2);
    rd_reg(A_STA, v); check("R11 no event on wrap", v, 0);

    // R6 compare disabled: no flag
    wr_reg(A_MLO, 32'h0);
    wr_reg(A_MHI, 32'h0);
    idle(5);
    rd_reg(A_STA, v); check("R6 disabled no flag", v, 0);
    check("R6 disabled no irq", irq, 0);

    // R5 greater-or-equal fires at once
    wr_reg(A_CTL, 32'h7);
    idle(2);
    rd_reg(A_STA, v); check("R5 ge event", v, 1);
    check("R10 irq on", irq, 1);

    // R9 write 0 no effect, write 1 clears
    wr_reg(A_STA, 32'h0);
    rd_reg(A_STA, v); check("R9 write zero ignored", v, 1);
    wr_reg(A_STA, 32'h1);
    rd_reg(A_STA, v); check("R9 clear", v, 0);
    check("R10 irq off after clear", irq, 0);

    // R7 one-shot stays quiet, re-enable re-arms
    idle(20);
    rd_reg(A_STA, v); check("R7 no second event", v, 0);
    wr_reg(A_CTL, 32'h5);
    wr_reg(A_CTL, 32'h7);
    idle(2);
    rd_reg(A_STA, v); check("R7 rearm on enable", v, 1);
    wr_reg(A_STA, 32'h1);

    // R5 future compare: not early, then fires
    rd_reg(A_CLO, a);
    wr_reg(A_CTL, 32'h5);
    wr_reg(A_MLO, a + 32'd60);
    wr_reg(A_CTL, 32'h7);
    idle(20);
    rd_reg(A_STA, v); check("R5 not before compare", v, 0);
    idle(60);
    rd_reg(A_STA, v); check("R5 reached compare", v, 1);
    wr_reg(A_STA, 32'h1);

    // R10 gating by interrupt enable
    wr_reg(A_CTL, 32'h1);
    wr_reg(A_MLO, 32'h0);
    wr_reg(A_CTL, 32'h3);
    idle(2);
    rd_reg(A_STA, v); check("R10 flag set", v, 1);
    check("R10 irq masked", irq, 0);
    wr_reg(A_CTL, 32'h7);
    check("R10 irq unmasked", irq, 1);
    wr_reg(A_STA, 32'h1);

    // R8 periodic catch-up with the counter stopped
    for (int i = 0; i < 6; i++) begin
      logic [31:0] c, st, j, c0;
      c  = $urandom_range(1000, 100000);
      st = $urandom_range(1, 50);
      j  = $urandom_range(0, 4);
      c0 = c - j * st;
      wr_reg(A_CTL, 32'h0);
      wr_reg(A_STA, 32'h1);
      wr_reg(A_CLO, c);
      wr_reg(A_CHI, 32'h0);
      wr_reg(A_STP, st);
      wr_reg(A_MLO, c0);
      wr_reg(A_MHI, 32'h0);
      wr_reg(A_CTL, 32'hA);
      idle(8);
      rd_reg(A_MLO, v); check("R8 compare advanced", v, exp_periodic(c0, st, c));
      rd_reg(A_STA, v); check("R8 periodic flag", v, 1);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  localparam logic [4:0] A_LIST [7] = '{5'h00, 5'h04, 5'h08, 5'h0C, 5'h10, 5'h14, 5'h18};
endmodule